// File: doc/BRIEF.md
# Frame Reference-Level Threshold Counters

This block counts, over one frame, the pixels whose reference-level sample is too dark and those whose sample is too bright. Two comparators watch the 8-bit unsigned pixel value. One fires when the value is under 5, the other when it is over 123. Their accumulators advance only while the read-state qualifier is high.

At each rising edge of VSYNC, each accumulator is halved and copied into a 16-bit read-only result register, and the accumulator restarts for the next frame. The host reads each result as two bytes through a read address and applies the factor of two itself. A large dark count tells the host to raise the reset level, and a large bright count tells it to lower the reset level.

Top module: `ref_level_census`

## Requirements
- R1: The dark counter counts a pixel only when its unsigned value is strictly less than 5. A value of 4 counts and a value of 5 does not.
- R2: The bright counter counts a pixel only when its unsigned value is strictly greater than 123. A value of 124 counts and a value of 123 does not.
- R3: A pixel presented while `pix_qual_i` is low changes neither counter.
- R4: Each reported value is the frame's qualifying pixel count shifted right by one, so an odd count is truncated.
- R5: Address 8'h57 returns bits 15:8 of the dark result and 8'h58 returns bits 7:0. Address 8'h59 returns bits 15:8 of the bright result and 8'h5A returns bits 7:0.
- R6: After reset, all four result bytes read 00h.
- R7: The results change only on the clock after a cycle in which `vsync_i` is high and was low in the previous cycle. At every other time they hold, including while VSYNC stays high.
- R8: On a VSYNC rising-edge cycle the accumulators restart. A pixel that qualifies in that same cycle counts toward the new frame.
- R9: An accumulator that reaches 131071 stays there instead of wrapping, so an oversized frame reports FFFFh.
- R10: A read of any address other than 8'h57 to 8'h5A returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_qual_i | input | 1 | High while the sensor is in its read state with a valid pixel |
| pix_i | input | 8 | Pixel reference-level value, unsigned |
| vsync_i | input | 1 | Frame marker; the rising edge closes a frame |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Read data byte (combinational from address) |

## Verification
The bench sends the threshold neighbours 4, 5, 123 and 124. A comparator with the wrong inequality or an off-by-one threshold reports a count that is too high or too low. It holds VSYNC high across several pixel cycles and reads in the middle of a frame. A level-sensitive design would reload or clear on every high cycle, and that shows up as altered results. A qualifying pixel is placed in the rising-edge cycle itself, which exposes a design that drops that pixel or gives it to the old frame. One frame of more than 131071 dark pixels catches a counter that wraps to a small value. Frames with odd counts catch a design that rounds instead of truncating.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic {
    CMP_BELOW = 1'b0,
    CMP_ABOVE = 1'b1
  } cmp_mode_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/rlc_vsync_edge.sv
module rlc_vsync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  output logic rise_o
);
  logic vsync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vsync_q <= 1'b0;
    else         vsync_q <= vsync_i;
  end

  assign rise_o = vsync_i & ~vsync_q;
endmodule

// File: rtl/rlc_thresh_acc.sv
module rlc_thresh_acc
  import rlc_pkg::*;
#(
  parameter int unsigned     PIX_W  = 8,
  parameter int unsigned     ACC_W  = 17,
  parameter cmp_mode_e       MODE   = CMP_BELOW,
  parameter logic [PIX_W-1:0] THRESH = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             qual_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             frame_start_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic             cmp_hit;
  logic             hit;
  logic [ACC_W-1:0] acc_q;

  generate
    if (MODE == CMP_BELOW) begin : g_below
      assign cmp_hit = (pix_i < THRESH);
    end else begin : g_above
      assign cmp_hit = (pix_i > THRESH);
    end
  endgenerate

  assign hit = qual_i & cmp_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (frame_start_i) begin
      // edge-cycle pixel belongs to the new frame
      acc_q <= {{(ACC_W-1){1'b0}}, hit};
    end else if (hit && (acc_q != ACC_MAX)) begin
      acc_q <= acc_q + 1'b1;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/rlc_snap_regs.sv
module rlc_snap_regs
  import rlc_pkg::*;
#(
  parameter int unsigned       N_CNT     = 2,
  parameter int unsigned       CNT_W     = 16,
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 8'h57,
  localparam int unsigned      ACC_W     = CNT_W + 1,
  localparam int unsigned      NB        = CNT_W / BYTE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        frame_start_i,
  input  logic [N_CNT-1:0][ACC_W-1:0] acc_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [N_CNT-1:0][CNT_W-1:0] snap_o,
  output logic [BYTE_W-1:0]           rd_data_o
);
  logic [N_CNT-1:0][CNT_W-1:0] snap_q;

  for (genvar k = 0; k < N_CNT; k++) begin : g_snap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            snap_q[k] <= '0;
      else if (frame_start_i) snap_q[k] <= acc_i[k][ACC_W-1:1];
    end
  end

  // most significant byte at the lowest address of each counter
  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < N_CNT; k++) begin
      for (int j = 0; j < NB; j++) begin
        if (rd_addr_i == ADDR_BASE + ADDR_W'(k * NB + j))
          rd_data_o = snap_q[k][(NB-1-j)*BYTE_W +: BYTE_W];
      end
    end
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/ref_level_census.sv
module ref_level_census
  import rlc_pkg::*;
#(
  parameter int unsigned       PIX_W     = 8,
  parameter int unsigned       CNT_W     = 16,
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 8'h57,
  parameter logic [PIX_W-1:0]  LO_THR    = 8'd5,
  parameter logic [PIX_W-1:0]  HI_THR    = 8'd123
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_qual_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              vsync_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned N_CNT = 2;
  localparam int unsigned ACC_W = CNT_W + 1;

  logic                        frame_start;
  logic [N_CNT-1:0][ACC_W-1:0] acc_q;
  logic [N_CNT-1:0][CNT_W-1:0] snap_q;

  rlc_vsync_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vsync_i (vsync_i),
    .rise_o  (frame_start)
  );

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    localparam cmp_mode_e        MODE = (k == 0) ? CMP_BELOW : CMP_ABOVE;
    localparam logic [PIX_W-1:0] THR  = (k == 0) ? LO_THR : HI_THR;
    rlc_thresh_acc #(
      .PIX_W  (PIX_W),
      .ACC_W  (ACC_W),
      .MODE   (MODE),
      .THRESH (THR)
    ) u_acc (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .qual_i        (pix_qual_i),
      .pix_i         (pix_i),
      .frame_start_i (frame_start),
      .acc_o         (acc_q[k])
    );
  end

  rlc_snap_regs #(
    .N_CNT     (N_CNT),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .ADDR_BASE (ADDR_BASE)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start),
    .acc_i         (acc_q),
    .rd_addr_i     (rd_addr_i),
    .snap_o        (snap_q),
    .rd_data_o     (rd_data_o)
  );
endmodule

// File: rtl/ref_level_census_chk.sv
module ref_level_census_chk #(
  parameter int unsigned ACC_W = 17,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vsync_i,
  input logic             pix_qual_i,
  input logic [7:0]       rd_addr_i,
  input logic [7:0]       rd_data_o,
  input logic [ACC_W-1:0] lo_acc_i,
  input logic [ACC_W-1:0] hi_acc_i,
  input logic [CNT_W-1:0] lo_snap_i,
  input logic [CNT_W-1:0] hi_snap_i
);
  logic vs_d;
  logic rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_d <= 1'b0;
    else         vs_d <= vsync_i;
  end
  assign rise = vsync_i & ~vs_d;

  p_reset_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rd_data_o == 8'h00));

  p_halved_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (lo_snap_i == $past(lo_acc_i[ACC_W-1:1])));

  p_halved_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (hi_snap_i == $past(hi_acc_i[ACC_W-1:1])));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise && rst_ni) |=> ($stable(lo_snap_i) && $stable(hi_snap_i)));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !pix_qual_i) |=> (lo_acc_i == '0 && hi_acc_i == '0));

  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_acc_i == '1 && !rise) |=> (lo_acc_i == '1));

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i < 8'h57 || rd_addr_i > 8'h5A) |-> (rd_data_o == 8'h00));
endmodule

bind ref_level_census ref_level_census_chk #(
  .ACC_W (ACC_W),
  .CNT_W (CNT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vsync_i    (vsync_i),
  .pix_qual_i (pix_qual_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .lo_acc_i   (acc_q[0]),
  .hi_acc_i   (acc_q[1]),
  .lo_snap_i  (snap_q[0]),
  .hi_snap_i  (snap_q[1])
);

// File: tb/ref_level_census_tb_top.sv
module ref_level_census_tb_top;
  localparam int ACC_MAX = 131071;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       qual = 1'b0;
  logic [7:0] pix = '0;
  logic       vsync = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int          m_lo = 0, m_hi = 0;
  logic [15:0] e_lo = '0, e_hi = '0;
  bit          prev_v = 1'b0;

  always #4ns clk = ~clk;

  ref_level_census dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pix_qual_i (qual),
    .pix_i      (pix),
    .vsync_i    (vsync),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data)
  );

  function automatic bit is_dark(bit q, logic [7:0] p);
    return q && (p < 8'd5);
  endfunction

  function automatic bit is_bright(bit q, logic [7:0] p);
    return q && (p > 8'd123);
  endfunction

  task automatic step(bit q, logic [7:0] p, bit v);
    @(negedge clk);
    qual = q; pix = p; vsync = v;
    if (v && !prev_v) begin
      e_lo = 16'(m_lo >> 1);
      e_hi = 16'(m_hi >> 1);
      m_lo = is_dark(q, p) ? 1 : 0;
      m_hi = is_bright(q, p) ? 1 : 0;
    end else begin
      if (is_dark(q, p) && m_lo < ACC_MAX) m_lo++;
      if (is_bright(q, p) && m_hi < ACC_MAX) m_hi++;
    end
    prev_v = v;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    qual = 1'b0;
    rd_addr = a;
    #1ns;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_all(string req);
    rd_chk(8'h57, e_lo[15:8], req);
    rd_chk(8'h58, e_lo[7:0], req);
    rd_chk(8'h59, e_hi[15:8], req);
    rd_chk(8'h5A, e_hi[7:0], req);
  endtask

  // one-cycle rising edge closing the frame, then VSYNC low
  task automatic close_frame();
    step(1'b0, 8'd0, 1'b1);
    step(1'b0, 8'd0, 1'b0);
  endtask

  initial begin
    #(8ns * 195000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6 reset state
    chk_all("R6");

    // R1 R2 R3 threshold neighbours, qualifier gating
    step(1'b1, 8'd0, 1'b0);
    step(1'b1, 8'd4, 1'b0);
    step(1'b1, 8'd5, 1'b0);
    step(1'b1, 8'd123, 1'b0);
    step(1'b1, 8'd124, 1'b0);
    step(1'b1, 8'd255, 1'b0);
    step(1'b1, 8'd4, 1'b0);
    step(1'b1, 8'd200, 1'b0);
    step(1'b0, 8'd0, 1'b0);
    step(1'b0, 8'd255, 1'b0);
    close_frame();
    rd_chk(8'h58, 8'h01, "R1"); // dark 0,4,4 -> 3 >> 1
    rd_chk(8'h5A, 8'h01, "R2"); // bright 124,255,200 -> 3 >> 1
    rd_chk(8'h57, 8'h00, "R5");
    rd_chk(8'h59, 8'h00, "R5");

    // R3 qualifier low only
    for (int i = 0; i < 40; i++) step(1'b0, (i % 2) ? 8'd0 : 8'd250, 1'b0);
    close_frame();
    rd_chk(8'h58, 8'h00, "R3");
    rd_chk(8'h5A, 8'h00, "R3");

    // R4 odd truncation, R8 pixel in the edge cycle
    for (int i = 0; i < 7; i++) step(1'b1, 8'd1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 8'd130, 1'b0);
    step(1'b1, 8'd2, 1'b1);     // edge cycle: dark pixel for new frame
    step(1'b1, 8'd2, 1'b1);     // VSYNC still high, no new edge
    step(1'b1, 8'd2, 1'b1);
    step(1'b0, 8'd0, 1'b0);
    rd_chk(8'h58, 8'h03, "R4");
    rd_chk(8'h5A, 8'h02, "R4");
    // R7 mid-frame hold
    for (int i = 0; i < 30; i++) step(1'b1, 8'd0, 1'b0);
    rd_chk(8'h58, 8'h03, "R7");
    rd_chk(8'h5A, 8'h02, "R7");
    close_frame();
    rd_chk(8'h58, 8'd16, "R8"); // 3 + 30 = 33 >> 1
    chk_all("R8");

    // random frames
    for (int f = 0; f < 15; f++) begin
      int len = 50 + int'($urandom_range(350));
      for (int i = 0; i < len; i++) begin
        int sel = int'($urandom_range(3));
        logic [7:0] p;
        case (sel)
          0: p = 8'($urandom_range(6));
          1: p = 8'(121 + $urandom_range(5));
          default: p = 8'($urandom);
        endcase
        step(bit'($urandom_range(1)), p, (i > 10 && i < 14) ? bit'($urandom_range(1)) : 1'b0);
        if (i == len / 2) chk_all("R7");
      end
      step(bit'($urandom_range(1)), 8'($urandom_range(8)), 1'b1);
      step(1'b0, 8'd0, 1'b0);
      chk_all("R4");
    end

    // R9 saturation
    for (int i = 0; i < ACC_MAX + 40; i++) step(1'b1, 8'd0, 1'b0);
    close_frame();
    rd_chk(8'h57, 8'hFF, "R9");
    rd_chk(8'h58, 8'hFF, "R9");

    // R10 unmapped addresses
    rd_chk(8'h00, 8'h00, "R10");
    rd_chk(8'h56, 8'h00, "R10");
    rd_chk(8'h5B, 8'h00, "R10");
    rd_chk(8'hFF, 8'h00, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule